// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a minimal processor that completes one instruction per clock cycle. It supports five operations: two register-to-register operations (add and bitwise or), a word load, a word store, and a branch taken on equality. It contains a program counter, an instruction store organised as bytes, a 32-entry register file, a word-organised data store, an adder/or unit, and decode logic. The processor runs from a clock and an active-low reset. The current instruction address is visible on an output.

While reset is held, the program, the register values and the data words are written through one preload port. The same contents can be read back through a peek port, so that a bench can observe results after a run. Any opcode or function code outside the supported set behaves as a no-operation. The program counter still moves on by four when such an instruction is fetched.

Top module: `mini_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and stays at 0 across clock edges. Asserting rst_ni clears pc_o without waiting for a clock edge.
- R2: When the fetched instruction is not a taken branch, each rising edge with rst_ni high advances pc_o by 4.
- R3: An instruction word is built from four consecutive bytes of the instruction store, with the lowest address as the most significant byte. Preload and peek select 2 address that store, one byte per address, and preload uses load_data_i[7:0].
- R4: Opcode bits [31:26] = 0x00 with function bits [5:0] = 0x20 writes rs+rt, modulo 2^32, to rd. The register fields are rs = [25:21], rt = [20:16] and rd = [15:11].
- R5: Opcode 0x00 with function 0x25 writes rs | rt to rd.
- R6: Opcode 0x23 loads into rt the data word at word index (rs + sign-extended imm[15:0]) >> 2.
- R7: Opcode 0x2B stores rt into the data word at word index (rs + sign-extended imm[15:0]) >> 2. Preload and peek select 1 address data words by word index.
- R8: Opcode 0x04 compares rs with rt. When they are equal, the next pc is pc+4 plus the sign-extended imm shifted left by two. Otherwise the next pc is pc+4.
- R9: Register 0 always reads as zero, both as an operand and through peek select 0. Core writes and preload writes to register 0 are ignored.
- R10: Any other opcode, or opcode 0x00 with any other function code, changes no register and no data word. It advances the pc by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; halts the core |
| load_en_i | input | 1 | Preload write strobe |
| load_sel_i | input | 2 | Preload target: 0 register, 1 data word, 2 instruction byte |
| load_addr_i | input | ADDR_W | Preload index within the selected store |
| load_data_i | input | 32 | Preload value (only [7:0] for instruction bytes) |
| peek_sel_i | input | 2 | Read-back source: 0 register, 1 data word, 2 instruction word |
| peek_addr_i | input | ADDR_W | Read-back index (byte address for instruction words) |
| peek_data_o | output | 32 | Combinational read-back value |
| pc_o | output | 32 | Current instruction address |

## Verification
The bench builds the core with a 64-byte instruction store and a 16-word data store. At that size, load and store sweeps reach every data word from a base register, with both positive and negative offsets. Add and or run over a cross product of operand values that includes carry-out and all-ones patterns. Branches are run with forward, zero and backward offsets, each both taken and not taken. A short program confirms that a taken branch skips an instruction and that later loads see earlier stores.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [5:0] {
    OP_RTYPE = 6'h00,
    OP_BEQ   = 6'h04,
    OP_LW    = 6'h23,
    OP_SW    = 6'h2B
  } opcode_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    SEL_REG   = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_INSTR = 2'd2
  } port_sel_e;

  typedef struct packed {
    logic valid;
    logic reg_we;
    logic dst_rd;
    logic use_imm;
    logic mem_to_reg;
    logic mem_we;
    logic is_beq;
    logic alu_or;
  } ctrl_t;
endpackage

// File: rtl/mc_imem.sv
module mc_imem #(
  parameter int BYTES = 256,
  localparam int AW = $clog2(BYTES)
)(
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [31:0]   rdata_a_o,
  output logic [31:0]   rdata_b_o
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // big-endian assembly: lane 0 (lowest address) lands in [31:24]
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [AW-1:0] addr_a, addr_b;
    assign addr_a = raddr_a_i + AW'(k);
    assign addr_b = raddr_b_i + AW'(k);
    assign rdata_a_o[31-8*k -: 8] = mem[addr_a];
    assign rdata_b_o[31-8*k -: 8] = mem[addr_b];
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mini_core_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] waddr_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [RIDX_W-1:0] raddr_a_i,
  input  logic [RIDX_W-1:0] raddr_b_i,
  input  logic [RIDX_W-1:0] raddr_c_i,
  output logic [XLEN-1:0]   rdata_a_o,
  output logic [XLEN-1:0]   rdata_b_o,
  output logic [XLEN-1:0]   rdata_c_o
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk_i) begin
    if (we_i && waddr_i != '0) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : mem[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : mem[raddr_b_i];
  assign rdata_c_o = (raddr_c_i == '0) ? '0 : mem[raddr_c_i];
endmodule

// File: rtl/mc_dmem.sv
module mc_dmem
  import mini_core_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
)(
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/mc_decode.sv
module mc_decode
  import mini_core_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (op_i)
      OP_RTYPE: begin
        if (fn_i == FN_ADD || fn_i == FN_OR) begin
          ctrl_o.valid  = 1'b1;
          ctrl_o.reg_we = 1'b1;
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.alu_or = (fn_i == FN_OR);
        end
      end
      OP_LW: begin
        ctrl_o.valid      = 1'b1;
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.use_imm    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl_o.valid   = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.valid  = 1'b1;
        ctrl_o.is_beq = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mini_core.sv
module mini_core
  import mini_core_pkg::*;
#(
  parameter int IMEM_BYTES = 256,
  parameter int DMEM_WORDS = 64,
  parameter int ADDR_W     = 16
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [1:0]        load_sel_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [XLEN-1:0]   load_data_i,
  input  logic [1:0]        peek_sel_i,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [XLEN-1:0]   peek_data_o,
  output logic [XLEN-1:0]   pc_o
);
  localparam int IA_W = $clog2(IMEM_BYTES);
  localparam int DA_W = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target;
  logic [XLEN-1:0]   instr, imem_peek;
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] rs, rt, rd;
  logic [15:0]       imm;
  logic [XLEN-1:0]   imm_sext, rs_val, rt_val, alu_b, alu_res;
  logic [XLEN-1:0]   dmem_rdata, wb_data, rf_peek, dm_peek;
  logic              take_br, core_rf_we, core_dm_we;
  logic              ld_reg, ld_data, ld_imem;
  logic              rf_we, dm_we;
  logic [RIDX_W-1:0] rf_waddr;
  logic [XLEN-1:0]   rf_wdata, dm_wdata;
  logic [DA_W-1:0]   dm_waddr;
  logic              unused_bits;

  // field split
  assign rs       = instr[25:21];
  assign rt       = instr[20:16];
  assign rd       = instr[15:11];
  assign imm      = instr[15:0];
  assign imm_sext = {{(XLEN-16){imm[15]}}, imm};

  mc_decode u_decode (
    .op_i   (instr[31:26]),
    .fn_i   (instr[5:0]),
    .ctrl_o (ctrl)
  );

  // preload decode
  assign ld_reg  = load_en_i && (port_sel_e'(load_sel_i) == SEL_REG);
  assign ld_data = load_en_i && (port_sel_e'(load_sel_i) == SEL_DATA);
  assign ld_imem = load_en_i && (port_sel_e'(load_sel_i) == SEL_INSTR);

  // core writes only run out of reset; preload takes the write port first
  assign core_rf_we = rst_ni && ctrl.reg_we;
  assign core_dm_we = rst_ni && ctrl.mem_we;

  assign rf_we    = ld_reg || core_rf_we;
  assign rf_waddr = ld_reg ? load_addr_i[RIDX_W-1:0] : (ctrl.dst_rd ? rd : rt);
  assign rf_wdata = ld_reg ? load_data_i : wb_data;

  assign dm_we    = ld_data || (core_dm_we && !ld_reg && !ld_imem);
  assign dm_waddr = ld_data ? load_addr_i[DA_W-1:0] : alu_res[DA_W+1:2];
  assign dm_wdata = ld_data ? load_data_i : rt_val;

  mc_imem #(.BYTES(IMEM_BYTES)) u_imem (
    .clk_i     (clk_i),
    .we_i      (ld_imem),
    .waddr_i   (load_addr_i[IA_W-1:0]),
    .wdata_i   (load_data_i[7:0]),
    .raddr_a_i (pc_q[IA_W-1:0]),
    .raddr_b_i (peek_addr_i[IA_W-1:0]),
    .rdata_a_o (instr),
    .rdata_b_o (imem_peek)
  );

  mc_regfile u_regfile (
    .clk_i     (clk_i),
    .we_i      (rf_we && !(ld_data || ld_imem)),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .raddr_c_i (peek_addr_i[RIDX_W-1:0]),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val),
    .rdata_c_o (rf_peek)
  );

  mc_dmem #(.WORDS(DMEM_WORDS)) u_dmem (
    .clk_i     (clk_i),
    .we_i      (dm_we),
    .waddr_i   (dm_waddr),
    .wdata_i   (dm_wdata),
    .raddr_a_i (alu_res[DA_W+1:2]),
    .raddr_b_i (peek_addr_i[DA_W-1:0]),
    .rdata_a_o (dmem_rdata),
    .rdata_b_o (dm_peek)
  );

  // execute
  assign alu_b   = ctrl.use_imm ? imm_sext : rt_val;
  assign alu_res = ctrl.alu_or ? (rs_val | alu_b) : (rs_val + alu_b);
  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_res;

  // next pc
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.is_beq && (rs_val == rt_val);
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  always_comb begin
    case (port_sel_e'(peek_sel_i))
      SEL_REG:   peek_data_o = rf_peek;
      SEL_DATA:  peek_data_o = dm_peek;
      SEL_INSTR: peek_data_o = imem_peek;
      default:   peek_data_o = '0;
    endcase
  end

  assign unused_bits = ^{instr[10:6], load_addr_i, peek_addr_i, alu_res, pc_q};

  // R2: sequential flow
  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_br |=> pc_q == $past(pc_q) + 32'd4);

  // R8: taken branch lands on pc+4+offset*4
  a_r8_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_br |=> pc_q == $past(pc_q) + 32'd4 + {$past(imm_sext[XLEN-3:0]), 2'b00});

  // R9: register 0 operand from the regfile is zero
  a_r9_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs == '0) |-> (rs_val == '0));

  // R10: undecoded instructions cause no writes
  a_r10_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.valid && !load_en_i) |-> (!rf_we && !dm_we));

  // R7: data writes during a run come only from a store
  a_r7_store_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_we && !load_en_i) |-> (instr[31:26] == 6'h2B));
endmodule

// File: tb/mini_core_tb.sv
module mini_core_tb;
  import mini_core_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IMEM_BYTES = 64;
  localparam int DMEM_WORDS = 16;
  localparam int ADDR_W     = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_en_i = 1'b0;
  logic [1:0]        load_sel_i = '0;
  logic [ADDR_W-1:0] load_addr_i = '0;
  logic [31:0]       load_data_i = '0;
  logic [1:0]        peek_sel_i = '0;
  logic [ADDR_W-1:0] peek_addr_i = '0;
  logic [31:0]       peek_data_o;
  logic [31:0]       pc_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  mini_core #(.IMEM_BYTES(IMEM_BYTES), .DMEM_WORDS(DMEM_WORDS), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(load_en_i), .load_sel_i(load_sel_i),
    .load_addr_i(load_addr_i), .load_data_i(load_data_i), .peek_sel_i(peek_sel_i),
    .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o), .pc_o(pc_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(logic [1:0] sel, int addr, logic [31:0] data);
    load_en_i   = 1'b1;
    load_sel_i  = sel;
    load_addr_i = addr[ADDR_W-1:0];
    load_data_i = data;
    @(negedge clk_i);
    load_en_i   = 1'b0;
  endtask

  task automatic put_instr(int baddr, logic [31:0] w);
    for (int k = 0; k < 4; k++) load(SEL_INSTR, baddr + k, {24'd0, w[31-8*k -: 8]});
  endtask

  task automatic peek(logic [1:0] sel, int addr, output logic [31:0] v);
    peek_sel_i  = sel;
    peek_addr_i = addr[ADDR_W-1:0];
    #1;
    v = peek_data_o;
  endtask

  task automatic run_edges(int n);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic halt();
    rst_ni = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] r_word(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] i_word(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] vals [5];
    logic [15:0] offs [5];
    vals = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678};
    offs = '{16'h0000, 16'h0001, 16'h0005, 16'hFFFF, 16'hFFFD};

    // R1: pc held at zero under reset while the clock runs
    repeat (3) @(negedge clk_i);
    check("R1 reset pc", pc_o, 32'd0);
    repeat (2) @(negedge clk_i);
    check("R1 reset pc hold", pc_o, 32'd0);

    // R3: big-endian word assembly from bytes
    load(SEL_INSTR, 8,  32'hA1);
    load(SEL_INSTR, 9,  32'hB2);
    load(SEL_INSTR, 10, 32'hC3);
    load(SEL_INSTR, 11, 32'hD4);
    peek(SEL_INSTR, 8, v);
    check("R3 byte order", v, 32'hA1B2C3D4);
    put_instr(0, 32'h0123_4567);
    peek(SEL_INSTR, 0, v);
    check("R3 word roundtrip", v, 32'h0123_4567);

    // R4 add sweep, with R2 pc step
    put_instr(0, r_word(9, 10, 11, 6'h20));
    foreach (vals[i]) foreach (vals[j]) begin
      load(SEL_REG, 9, vals[i]);
      load(SEL_REG, 10, vals[j]);
      run_edges(1);
      check("R2 pc after add", pc_o, 32'd4);
      halt();
      check("R1 async clear", pc_o, 32'd0);
      peek(SEL_REG, 11, v);
      check("R4 add", v, vals[i] + vals[j]);
    end

    // R5 or sweep
    put_instr(0, r_word(9, 10, 12, 6'h25));
    foreach (vals[i]) foreach (vals[j]) begin
      load(SEL_REG, 9, vals[i]);
      load(SEL_REG, 10, vals[j] ^ 32'h00FF_0F0F);
      run_edges(1);
      halt();
      peek(SEL_REG, 12, v);
      check("R5 or", v, vals[i] | (vals[j] ^ 32'h00FF_0F0F));
    end

    // R6 load sweep: base 16, offsets reach every word, negative included
    for (int w = 0; w < DMEM_WORDS; w++) load(SEL_DATA, w, 32'hC0DE_0000 + w);
    load(SEL_REG, 9, 32'd16);
    for (int w = 0; w < DMEM_WORDS; w++) begin
      logic [15:0] off;
      off = 16'(4 * w - 16);
      put_instr(0, i_word(6'h23, 9, 12, off));
      run_edges(1);
      check("R2 pc after lw", pc_o, 32'd4);
      halt();
      peek(SEL_REG, 12, v);
      check("R6 lw", v, 32'hC0DE_0000 + w);
    end

    // R7 store sweep: base 8
    load(SEL_REG, 9, 32'd8);
    for (int w = 0; w < DMEM_WORDS; w++) begin
      logic [15:0] off;
      off = 16'(4 * w - 8);
      load(SEL_REG, 10, 32'h5A00_0000 ^ (w * 3 + 1));
      put_instr(0, i_word(6'h2B, 9, 10, off));
      run_edges(1);
      halt();
      peek(SEL_DATA, w, v);
      check("R7 sw", v, 32'h5A00_0000 ^ (w * 3 + 1));
      if (w + 1 < DMEM_WORDS) begin
        peek(SEL_DATA, w + 1, v);
        check("R7 neighbour untouched", v, 32'hC0DE_0000 + w + 1);
      end
    end

    // R8 branch: taken and not taken over several offsets
    foreach (offs[i]) begin
      logic [31:0] tgt;
      tgt = 32'd4 + ({{16{offs[i][15]}}, offs[i]} << 2);
      put_instr(0, i_word(6'h04, 9, 10, offs[i]));
      load(SEL_REG, 9, 32'hABCD_0000 + i);
      load(SEL_REG, 10, 32'hABCD_0000 + i);
      run_edges(1);
      check("R8 beq taken", pc_o, tgt);
      halt();
      load(SEL_REG, 10, 32'hABCD_8000 + i);
      run_edges(1);
      check("R8 beq not taken", pc_o, 32'd4);
      halt();
    end

    // R9: register 0
    load(SEL_REG, 0, 32'hFFFF_FFFF);
    peek(SEL_REG, 0, v);
    check("R9 preload r0 ignored", v, 32'd0);
    put_instr(0, r_word(9, 10, 0, 6'h20));
    load(SEL_REG, 9, 32'd5);
    load(SEL_REG, 10, 32'd6);
    run_edges(1);
    halt();
    peek(SEL_REG, 0, v);
    check("R9 write r0 ignored", v, 32'd0);
    put_instr(0, r_word(0, 10, 11, 6'h20));
    run_edges(1);
    halt();
    peek(SEL_REG, 11, v);
    check("R9 r0 operand zero", v, 32'd6);

    // R10: unsupported encodings are no-ops
    load(SEL_REG, 11, 32'h0000_1111);
    load(SEL_DATA, 0, 32'h0BAD_F00D);
    load(SEL_REG, 9, 32'd0);
    put_instr(0, i_word(6'h08, 9, 11, 16'h0003));
    run_edges(1);
    check("R10 pc after unknown op", pc_o, 32'd4);
    halt();
    peek(SEL_REG, 11, v);
    check("R10 unknown op no write", v, 32'h0000_1111);
    put_instr(0, r_word(9, 10, 11, 6'h22));
    run_edges(1);
    check("R10 pc after unknown fn", pc_o, 32'd4);
    halt();
    peek(SEL_REG, 11, v);
    check("R10 unknown fn no write", v, 32'h0000_1111);
    put_instr(0, i_word(6'h28, 9, 10, 16'h0000));
    run_edges(1);
    halt();
    peek(SEL_DATA, 0, v);
    check("R10 unknown store-like no write", v, 32'h0BAD_F00D);

    // R2/R8 program: add, or, beq skip, add(skipped), sw, lw
    put_instr(0,  r_word(9, 10, 11, 6'h20));
    put_instr(4,  r_word(11, 15, 12, 6'h25));
    put_instr(8,  i_word(6'h04, 9, 9, 16'h0001));
    put_instr(12, r_word(9, 10, 13, 6'h20));
    put_instr(16, i_word(6'h2B, 0, 12, 16'h0008));
    put_instr(20, i_word(6'h23, 0, 14, 16'h0008));
    load(SEL_REG, 9, 32'h0000_1001);
    load(SEL_REG, 10, 32'h0000_0110);
    load(SEL_REG, 13, 32'd0);
    load(SEL_REG, 14, 32'd0);
    load(SEL_REG, 15, 32'hA000_0000);
    rst_ni = 1'b1;
    @(negedge clk_i); check("R2 prog pc1", pc_o, 32'd4);
    @(negedge clk_i); check("R2 prog pc2", pc_o, 32'd8);
    @(negedge clk_i); check("R8 prog skip", pc_o, 32'd16);
    @(negedge clk_i); check("R2 prog pc4", pc_o, 32'd20);
    @(negedge clk_i); check("R2 prog pc5", pc_o, 32'd24);
    halt();
    peek(SEL_REG, 11, v);  check("R4 prog add", v, 32'h0000_1111);
    peek(SEL_REG, 12, v);  check("R5 prog or", v, 32'hA000_1111);
    peek(SEL_REG, 13, v);  check("R8 prog skipped", v, 32'd0);
    peek(SEL_DATA, 2, v);  check("R7 prog sw", v, 32'hA000_1111);
    peek(SEL_REG, 14, v);  check("R6 prog lw", v, 32'hA000_1111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule